// File: doc/BRIEF.md
# Row/Column Multiplexed Parallel Programming Port

This block is the front end of a flash device's parallel programming port. It is active only when the interface strap is high. The host sends a wide array address in two halves over the same eleven address pins. A row/column strobe marks which half is on the pins. The block keeps both halves in holding registers and presents the joined address to the rest of the chip. The upper half comes from the column phase and the lower half from the row phase.

The block samples the port's reset, output-enable and write-enable pins on the internal clock and decodes them into operations. A read returns array data on the 8-bit data bus. When an identification request is active, a read returns a fixed identity byte instead. The two lowest address bits select which byte. A write issues a single request pulse carrying the captured data byte. Timing-parameter checks and the array itself are handled elsewhere.

The controller is a state machine with six states: PARKED, RESET, STANDBY, READ, WRITE and INHIBIT. It decodes the next state on every clock. Strap low goes to PARKED; this takes priority. Reset low goes to RESET. Output-enable low with write-enable high goes to READ. Write-enable low with output-enable high goes to WRITE. Both enables high goes to STANDBY. Both enables low goes to INHIBIT. The transition that enters WRITE from any other state is the only one that issues a write request.

Top module: `mux_addr_port`

## Requirements
- R1: While `mode_sel` is low, the port is parked. `data_oe`, `rd_req` and `wr_req` stay 0, and strobe edges do not change `int_addr`.
- R2: A high-to-low transition of `rc_sel` stores `addr_in` into `int_addr[10:0]`. The new value is visible one clock after the edge is sampled.
- R3: A low-to-high transition of `rc_sel` stores `addr_in` into `int_addr[21:11]`. The new value is visible one clock after the edge is sampled.
- R4: `prt_rst_n` low clears `int_addr` to 0 at once and forces `data_oe`, `rd_req` and `wr_req` to 0, whatever the other inputs are.
- R5: With `oe_n` low, `we_n` high and `id_sel` low, the next clock gives a read: `data_oe` = 1, `rd_req` = 1 and `data_out` = `array_rdata`.
- R6: A clock that samples `we_n` low with `oe_n` high, after a clock that did not, raises `wr_req` for exactly one cycle. `wr_data` carries the `data_in` value sampled at that clock.
- R7: With both enables high (standby or output-disable), `data_oe`, `rd_req` and `wr_req` are 0 after the next clock.
- R8: Any clock that samples `oe_n` low gives `wr_req` = 0 on the following cycle. With both enables low, `data_oe` is also 0.
- R9: An identification read (`id_sel` high, read decode) keeps `rd_req` at 0 and drives `data_out` from `int_addr[1:0]`. 00 gives 0x37, 01 gives 0x9B, 11 gives 0x7F and 10 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| mode_sel | input | 1 | Interface strap; high enables this port |
| prt_rst_n | input | 1 | Port reset pin, active low, asynchronous |
| rc_sel | input | 1 | Row/column strobe; falling edge stores row, rising edge stores column |
| addr_in | input | 11 | Multiplexed address pins |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| id_sel | input | 1 | Identification read request from the command logic |
| data_in | input | 8 | Data pins, inbound |
| array_rdata | input | 8 | Array read data |
| data_out | output | 8 | Data pins, outbound |
| data_oe | output | 1 | Drive enable for the data pins |
| int_addr | output | 22 | Joined internal address, column half on top |
| rd_req | output | 1 | Array read request (level) |
| wr_req | output | 1 | Write request, one-cycle pulse |
| wr_data | output | 8 | Data byte for the write request |

## Verification
The bench walks a single one through every row bit and every column bit. A design that swapped the halves, or latched on the wrong strobe edge, would put the pattern in the wrong half of `int_addr`. It sweeps all four identification selector values, including the reserved one. A design that decoded the wrong address bits would return the wrong identity byte, or a nonzero byte for the reserved code. It holds write-enable low for several cycles, and drops it while output-enable is already low. A level-sensitive write, or a write that ignored the inhibit, would produce extra pulses. It also asserts reset in the middle of a read and with the strap low. A design with a synchronous reset, or one that let a parked port latch addresses, would show a driven bus or a non-zero address.

// File: rtl/mux_port_pkg.sv
package mux_port_pkg;

    typedef enum logic [2:0] {
        ST_PARKED,
        ST_RESET,
        ST_STANDBY,
        ST_READ,
        ST_WRITE,
        ST_INHIBIT
    } port_state_e;

    localparam int ID_SEL_W = 2;

endpackage

// File: rtl/rc_addr_latch.sv
module rc_addr_latch #(
    parameter int AW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            rc_sel,
    input  logic [AW-1:0]   addr_in,
    output logic [2*AW-1:0] addr_q
);

    logic rc_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_prev_q <= 1'b1;
        end else if (enable) begin
            rc_prev_q <= rc_sel;
        end
    end

    // half 0 (row, low bits) on falling strobe, half 1 (column, high bits) on rising
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic          hit;
        logic [AW-1:0] half_q;

        if (h == 0) begin : g_row
            assign hit = rc_prev_q && !rc_sel;
        end else begin : g_col
            assign hit = !rc_prev_q && rc_sel;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (enable && hit) begin
                half_q <= addr_in;
            end
        end

        assign addr_q[h*AW +: AW] = half_q;
    end

endmodule

// File: rtl/port_ctl_fsm.sv
module port_ctl_fsm
    import mux_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [DW-1:0] data_in,
    output port_state_e   state_o,
    output logic          wr_req,
    output logic [DW-1:0] wr_data
);

    port_state_e state_q, prev_q, state_d;
    logic [DW-1:0] wr_data_q;

    // next-state decode
    always_comb begin
        if (!mode_sel) begin
            state_d = ST_PARKED;
        end else begin
            unique case ({oe_n, we_n})
                2'b01:   state_d = ST_READ;
                2'b10:   state_d = ST_WRITE;
                2'b11:   state_d = ST_STANDBY;
                default: state_d = ST_INHIBIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            prev_q  <= ST_RESET;
        end else begin
            state_q <= state_d;
            prev_q  <= state_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_data_q <= '0;
        end else if (state_d == ST_WRITE && state_q != ST_WRITE) begin
            wr_data_q <= data_in;
        end
    end

    // outputs
    always_comb begin
        wr_req = 1'b0;
        unique case (state_q)
            ST_WRITE: wr_req = (prev_q != ST_WRITE);
            ST_PARKED, ST_RESET, ST_STANDBY, ST_READ, ST_INHIBIT: wr_req = 1'b0;
            default:  wr_req = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign wr_data = wr_data_q;

endmodule

// File: rtl/port_read_mux.sv
module port_read_mux
    import mux_port_pkg::*;
#(
    parameter int          DW      = 8,
    parameter logic [DW-1:0] MFR_ID  = 8'h37,
    parameter logic [DW-1:0] DEV_ID  = 8'h9B,
    parameter logic [DW-1:0] CONT_ID = 8'h7F
) (
    input  port_state_e         state,
    input  logic                id_sel,
    input  logic [ID_SEL_W-1:0] id_idx,
    input  logic [DW-1:0]       array_rdata,
    output logic [DW-1:0]       data_out,
    output logic                data_oe,
    output logic                rd_req
);

    logic [DW-1:0] id_byte;

    always_comb begin
        unique case (id_idx)
            2'b00:   id_byte = MFR_ID;
            2'b01:   id_byte = DEV_ID;
            2'b11:   id_byte = CONT_ID;
            default: id_byte = '0;
        endcase
    end

    always_comb begin
        data_oe  = 1'b0;
        rd_req   = 1'b0;
        data_out = '0;
        unique case (state)
            ST_READ: begin
                data_oe  = 1'b1;
                rd_req   = !id_sel;
                data_out = id_sel ? id_byte : array_rdata;
            end
            ST_PARKED, ST_RESET, ST_STANDBY, ST_WRITE, ST_INHIBIT: begin
                data_oe = 1'b0;
            end
            default: data_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/mux_addr_port.sv
module mux_addr_port
    import mux_port_pkg::*;
#(
    parameter int            AW      = 11,
    parameter int            DW      = 8,
    parameter logic [DW-1:0] MFR_ID  = 8'h37,
    parameter logic [DW-1:0] DEV_ID  = 8'h9B,
    parameter logic [DW-1:0] CONT_ID = 8'h7F
) (
    input  logic            clk,
    input  logic            mode_sel,
    input  logic            prt_rst_n,
    input  logic            rc_sel,
    input  logic [AW-1:0]   addr_in,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            id_sel,
    input  logic [DW-1:0]   data_in,
    input  logic [DW-1:0]   array_rdata,
    output logic [DW-1:0]   data_out,
    output logic            data_oe,
    output logic [2*AW-1:0] int_addr,
    output logic            rd_req,
    output logic            wr_req,
    output logic [DW-1:0]   wr_data
);

    localparam int IAW = 2 * AW;

    port_state_e      state;
    logic [IAW-1:0]   addr_q;

    rc_addr_latch #(.AW(AW)) u_latch (
        .clk     (clk),
        .rst_n   (prt_rst_n),
        .enable  (mode_sel),
        .rc_sel  (rc_sel),
        .addr_in (addr_in),
        .addr_q  (addr_q)
    );

    port_ctl_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (prt_rst_n),
        .mode_sel (mode_sel),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .data_in  (data_in),
        .state_o  (state),
        .wr_req   (wr_req),
        .wr_data  (wr_data)
    );

    port_read_mux #(
        .DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .CONT_ID(CONT_ID)
    ) u_rmux (
        .state       (state),
        .id_sel      (id_sel),
        .id_idx      (addr_q[ID_SEL_W-1:0]),
        .array_rdata (array_rdata),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .rd_req      (rd_req)
    );

    assign int_addr = addr_q;

endmodule

// File: rtl/mux_addr_port_chk.sv
module mux_addr_port_chk #(
    parameter int AW = 11
) (
    input logic            clk,
    input logic            mode_sel,
    input logic            prt_rst_n,
    input logic            oe_n,
    input logic            we_n,
    input logic            data_oe,
    input logic            rd_req,
    input logic            wr_req,
    input logic [2*AW-1:0] int_addr
);

    // R4
    always @(posedge clk) begin
        if (!prt_rst_n) begin
            rst_quiet_chk: assert (!data_oe && !rd_req && !wr_req && int_addr == '0);
        end
    end

    // R1
    parked_quiet_chk: assert property (@(posedge clk) disable iff (!prt_rst_n)
        $past(!mode_sel) |-> (!data_oe && !rd_req && !wr_req));

    // R1
    parked_addr_chk: assert property (@(posedge clk) disable iff (!prt_rst_n)
        $past(!mode_sel) |-> $stable(int_addr));

    // R5
    rd_drives_chk: assert property (@(posedge clk) disable iff (!prt_rst_n)
        rd_req |-> data_oe);

    // R6
    wr_single_chk: assert property (@(posedge clk) disable iff (!prt_rst_n)
        wr_req |=> !wr_req);

    // R6
    wr_cause_chk: assert property (@(posedge clk) disable iff (!prt_rst_n)
        wr_req |-> $past(!we_n && oe_n && mode_sel));

    // R7
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!prt_rst_n)
        $past(oe_n && we_n) |-> (!data_oe && !rd_req && !wr_req));

    // R8
    inhibit_chk: assert property (@(posedge clk) disable iff (!prt_rst_n)
        $past(!oe_n) |-> !wr_req);

endmodule

bind mux_addr_port mux_addr_port_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .mode_sel  (mode_sel),
    .prt_rst_n (prt_rst_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .data_oe   (data_oe),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .int_addr  (int_addr)
);

// File: tb/mux_addr_port_tb_top.sv
`timescale 1ns/1ps
module mux_addr_port_tb_top;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam logic [7:0] E_MFR  = 8'h37;
    localparam logic [7:0] E_DEV  = 8'h9B;
    localparam logic [7:0] E_CONT = 8'h7F;

    logic clk = 1'b0;
    logic mode_sel, prt_rst_n, rc_sel, oe_n, we_n, id_sel;
    logic [AW-1:0] addr_in;
    logic [DW-1:0] data_in, array_rdata, data_out, wr_data;
    logic data_oe, rd_req, wr_req;
    logic [2*AW-1:0] int_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mux_addr_port #(.AW(AW), .DW(DW), .MFR_ID(E_MFR), .DEV_ID(E_DEV), .CONT_ID(E_CONT)) dut_i (
        .clk(clk), .mode_sel(mode_sel), .prt_rst_n(prt_rst_n), .rc_sel(rc_sel),
        .addr_in(addr_in), .oe_n(oe_n), .we_n(we_n), .id_sel(id_sel),
        .data_in(data_in), .array_rdata(array_rdata), .data_out(data_out),
        .data_oe(data_oe), .int_addr(int_addr), .rd_req(rd_req),
        .wr_req(wr_req), .wr_data(wr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet(input string req);
        chk(req, {29'd0, data_oe, rd_req, wr_req}, 32'd0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mode_sel = 0; prt_rst_n = 0; rc_sel = 1; oe_n = 1; we_n = 1; id_sel = 0;
        addr_in = '0; data_in = '0; array_rdata = '0;
        #1; tick(); tick();
        quiet("R4 reset");
        chk("R4 reset addr", 32'(int_addr), 32'd0);

        // R1 parked: strobe edges and read controls ignored
        prt_rst_n = 1; tick();
        addr_in = 11'h155; rc_sel = 0; tick();
        addr_in = 11'h2AA; rc_sel = 1; tick();
        oe_n = 0; tick();
        quiet("R1 parked");
        chk("R1 parked addr", 32'(int_addr), 32'd0);
        oe_n = 1;

        prt_rst_n = 0; #1; mode_sel = 1; tick(); prt_rst_n = 1; tick();

        // R2 / R3 walking ones
        for (int i = 0; i < AW; i++) begin
            logic [AW-1:0] r, c;
            r = AW'(1) << i;
            c = AW'(1) << ((i + 3) % AW);
            addr_in = r; rc_sel = 0; tick();
            chk("R2 row half", 32'(int_addr[AW-1:0]), 32'(r));
            addr_in = c; rc_sel = 1; tick();
            chk("R3 column half", 32'(int_addr), 32'({c, r}));
        end

        // R5 array reads
        id_sel = 0; oe_n = 0; array_rdata = 8'h00; tick();
        for (int v = 0; v < 256; v += 37) begin
            array_rdata = 8'(v); #1;
            chk("R5 read", {22'd0, data_oe, rd_req, data_out}, {22'd0, 1'b1, 1'b1, 8'(v)});
        end
        oe_n = 1; tick();
        quiet("R7 standby");

        // R9 identification sweep
        id_sel = 1;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] e;
            e = (k == 0) ? E_MFR : (k == 1) ? E_DEV : (k == 3) ? E_CONT : 8'h00;
            addr_in = 11'(k); rc_sel = 0; tick(); rc_sel = 1; tick();
            oe_n = 0; tick();
            chk("R9 id read", {22'd0, data_oe, rd_req, data_out}, {22'd0, 1'b1, 1'b0, e});
            oe_n = 1; tick();
        end
        id_sel = 0;

        // R6 write pulses
        for (int w = 0; w < 4; w++) begin
            logic [7:0] d;
            d = 8'h3C ^ 8'(w * 85);
            data_in = d; we_n = 0; tick();
            chk("R6 write pulse", {23'd0, wr_req, wr_data}, {23'd0, 1'b1, d});
            data_in = ~d; tick();
            chk("R6 single pulse", 32'(wr_req), 32'd0);
            tick();
            chk("R6 data held", {23'd0, wr_req, wr_data}, {23'd0, 1'b0, d});
            we_n = 1; tick();
            quiet("R7 after write");
        end

        // R8 inhibit: both low from standby, then we falls during read
        oe_n = 0; we_n = 0; tick();
        quiet("R8 both low");
        tick();
        quiet("R8 both low hold");
        we_n = 1; tick();
        we_n = 0; tick();
        quiet("R8 we falls in read");
        oe_n = 1; we_n = 1; tick();

        // R4 asynchronous reset mid-read
        oe_n = 0; tick();
        chk("R4 pre-reset read", 32'(data_oe), 32'd1);
        prt_rst_n = 0; #1;
        quiet("R4 async");
        chk("R4 async addr", 32'(int_addr), 32'd0);
        tick(); prt_rst_n = 1; oe_n = 1; tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule